// File: doc/BRIEF.md
# Word-Counter Instruction Fetch Unit

This block keeps the program counter of a 32-bit core whose instructions are all one word long, and it supplies the word to execute next. The counter is word-granular: it holds 30 bits, and the byte address sent to instruction memory is that count with two zero bits appended. Sequential flow therefore needs only a +1 on the counter. A branch displacement is added in word units without any shift.

On every rising edge the counter takes one of three values. The first is the incremented count. The second is a branch target: the incremented count plus the sign-extended low 16 bits of the current instruction word. The third is a jump target: the top four bits of the incremented count joined to the low 26 bits of the instruction word. The surrounding core drives the branch and jump strobes and the ALU zero flag. It reads back the address and the fetched word in the same cycle.

The instruction store is a behavioural word array inside the block. It has a synchronous write port, which the core or a bench uses to place program words before or during execution.

Top module: `ifu_top`

## Requirements
- R1: `instrAddr` always equals the 30-bit word counter followed by two zero bits, so `instrAddr[1:0]` is always 0.
- R2: When `jump` is low and `branch` and `zero` are not both high, the next address is the current address plus 4. It wraps modulo 2^32.
- R3: When `branch` and `zero` are both high and `jump` is low, the next word count is (count + 1) + sign-extend(instr[15:0]). The offset is in words, not bytes.
- R4: A high `branch` with `zero` low has no effect: the address advances by 4 as in R2.
- R5: When `jump` is high, the next word count is {(count + 1)[29:26], instr[25:0]}. This holds whatever `branch` and `zero` are, so jump takes priority.
- R6: Reset is synchronous and active high. A rising edge with `rst` high sets the counter to 0, over any strobe.
- R7: `instr` is a combinational read of the store at word index `instrAddr[IDX_W+1:2]`. It is valid in the same cycle as the address.
- R8: When `memWe` is high on a rising edge, `memWdata` is written at index `memWaddr`. The new word is visible on `instr` from the following cycle whenever the counter's low IDX_W bits equal that index, so fetch addresses alias modulo the depth.
- R9: The word counter wraps at 30 bits. A branch from count 0 with offset -2 gives address 0xFFFFFFFC, and the next sequential step gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| branch | input | 1 | Conditional branch strobe |
| jump | input | 1 | Absolute jump strobe |
| zero | input | 1 | ALU zero flag qualifying a branch |
| memWe | input | 1 | Instruction store write enable |
| memWaddr | input | IDX_W (8) | Instruction store write word index |
| memWdata | input | 32 | Instruction store write data |
| instrAddr | output | 32 | Byte address of the current fetch |
| instr | output | 32 | Instruction word at the current address |

## Verification
On every cycle the assertions check the address arithmetic: the zero low bits, the +4 step, the word-scaled branch sum, the jump concatenation with its priority, and the reset value. They check each step against the previous address and instruction. Whether the fetched word matches what was written into the store, that aliasing holds modulo the depth, that a write made mid-run shows up at the right time, and that the 30-bit wrap is reached can be shown only by the bench. It does this by driving programs through a reference model and comparing address and word on every clock.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int WORD_W = 32;
  localparam int PC_W   = WORD_W - 2;
  localparam int IMM_W  = 16;
  localparam int JTGT_W = 26;
  localparam int HIGH_W = PC_W - JTGT_W;

  typedef struct packed {
    logic takeJump;
    logic takeBranch;
  } ifuStrobes_t;
endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
(
  input  logic        branch,
  input  logic        jump,
  input  logic        zero,
  output ifuStrobes_t strobes
);
  always_comb begin
    strobes.takeJump   = jump;
    strobes.takeBranch = branch & zero & ~jump;
  end
endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath
  import ifu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ifuStrobes_t       strobes,
  input  logic [JTGT_W-1:0] instrLow,
  output logic [PC_W-1:0]   pcWord
);
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] branchTgt;
  logic [PC_W-1:0] jumpTgt;
  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] offsetExt;

  always_comb begin
    pcInc     = pcWord + {{(PC_W-1){1'b0}}, 1'b1};
    offsetExt = {{(PC_W-IMM_W){instrLow[IMM_W-1]}}, instrLow[IMM_W-1:0]};
    branchTgt = pcInc + offsetExt;
    jumpTgt   = {pcInc[PC_W-1 -: HIGH_W], instrLow};
    if (strobes.takeJump)        pcNext = jumpTgt;
    else if (strobes.takeBranch) pcNext = branchTgt;
    else                         pcNext = pcInc;
  end

  always_ff @(posedge clk) begin
    if (rst) pcWord <= '0;
    else     pcWord <= pcNext;
  end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ifu_top.sv
module ifu_top
  import ifu_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  localparam int IDX_W = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch,
  input  logic              jump,
  input  logic              zero,
  input  logic              memWe,
  input  logic [IDX_W-1:0]  memWaddr,
  input  logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] instrAddr,
  output logic [WORD_W-1:0] instr
);
  ifuStrobes_t     strobes;
  logic [PC_W-1:0] pcWord;

  ifu_ctrl u_ctrl (
    .branch (branch),
    .jump   (jump),
    .zero   (zero),
    .strobes(strobes)
  );

  ifu_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .instrLow(instr[JTGT_W-1:0]),
    .pcWord  (pcWord)
  );

  ifu_imem #(.DEPTH(MEM_WORDS), .DATA_W(WORD_W)) u_mem (
    .clk  (clk),
    .we   (memWe),
    .waddr(memWaddr),
    .wdata(memWdata),
    .raddr(pcWord[IDX_W-1:0]),
    .rdata(instr)
  );

  assign instrAddr = {pcWord, 2'b00};
endmodule

// File: rtl/ifu_chk.sv
module ifu_chk (
  input logic        clk,
  input logic        rst,
  input logic        branch,
  input logic        jump,
  input logic        zero,
  input logic [31:0] instrAddr,
  input logic [31:0] instr
);
  logic [31:0] seqAddr;
  logic [31:0] brOffsetBytes;
  assign seqAddr       = instrAddr + 32'd4;
  assign brOffsetBytes = {{14{instr[15]}}, instr[15:0], 2'b00};

  p_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    instrAddr[1:0] == 2'b00);

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (!jump && !(branch && zero)) |=> instrAddr == $past(seqAddr));

  p_branch_r3: assert property (@(posedge clk) disable iff (rst)
    (branch && zero && !jump) |=> instrAddr == $past(seqAddr) + $past(brOffsetBytes));

  p_branch_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (branch && !zero && !jump) |=> instrAddr == $past(seqAddr));

  p_jump_r5: assert property (@(posedge clk) disable iff (rst)
    jump |=> instrAddr == {$past(seqAddr[31:28]), $past(instr[25:0]), 2'b00});

  p_reset_r6: assert property (@(posedge clk)
    rst |=> instrAddr == 32'd0);
endmodule

bind ifu_top ifu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .branch   (branch),
  .jump     (jump),
  .zero     (zero),
  .instrAddr(instrAddr),
  .instr    (instr)
);

// File: tb/sim_ifu_top.sv
`timescale 1ns/1ps
module sim_ifu_top;
  localparam int DEPTH = 256;
  localparam int IW    = 8;

  logic clk = 0;
  logic rst = 1;
  logic branch = 0, jump = 0, zero = 0, memWe = 0;
  logic [IW-1:0] memWaddr = '0;
  logic [31:0]   memWdata = '0;
  logic [31:0]   instrAddr, instr;

  ifu_top #(.MEM_WORDS(DEPTH)) u0 (
    .clk(clk), .rst(rst), .branch(branch), .jump(jump), .zero(zero),
    .memWe(memWe), .memWaddr(memWaddr), .memWdata(memWdata),
    .instrAddr(instrAddr), .instr(instr)
  );

  always #10 clk = ~clk;

  // reference state
  logic [29:0] pcM = '0;
  logic [31:0] memM [DEPTH];
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareNow(input string tag);
    check32(tag, instrAddr, {pcM, 2'b00});
    check32("R1", {30'd0, instrAddr[1:0]}, 32'd0);
    check32("R7", instr, memM[pcM[IW-1:0]]);
  endtask

  // one clock: inputs driven at the falling edge, model advanced to match
  task automatic step(input logic r, input logic b, input logic j, input logic z,
                      input logic we, input int widx, input logic [31:0] wd,
                      input string tag, input logic doCmp);
    logic [31:0] w;
    logic [29:0] inc, nxt;
    if (doCmp) compareNow(tag);
    rst = r; branch = b; jump = j; zero = z;
    memWe = we; memWaddr = widx[IW-1:0]; memWdata = wd;
    w   = memM[pcM[IW-1:0]];
    inc = pcM + 30'd1;
    if (r)           nxt = '0;
    else if (j)      nxt = {inc[29:26], w[25:0]};
    else if (b && z) nxt = inc + {{14{w[15]}}, w[15:0]};
    else             nxt = inc;
    @(posedge clk);
    pcM = nxt;
    if (we) memM[widx % DEPTH] = wd;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // preload the whole store under reset (R8)
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, 0, 1, i, (32'h9E3779B9 * (i + 7)) ^ 32'h0000_8000, "R8", 0);
    step(1, 0, 0, 0, 0, 0, 0, "R6", 1);
    compareNow("R6");

    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, "R2", 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, 0, "R4", 1);
    step(0, 0, 0, 1, 0, 0, 0, "R4", 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 0, 0, "R3", 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0, "R5", 1);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 0, 0, "R5", 1);

    // write the word about to be fetched next, then read it back (R8)
    step(0, 0, 0, 0, 1, (pcM + 1) % DEPTH, 32'hCAFE_0003, "R8", 1);
    step(0, 0, 0, 0, 0, 0, 0, "R8", 1);
    compareNow("R8");

    // reset in mid-run overrides a jump (R6)
    step(1, 1, 1, 1, 0, 0, 0, "R6", 1);
    compareNow("R6");

    // counter wrap through a negative branch from zero (R9)
    step(1, 0, 0, 0, 1, 0, 32'h0000_FFFE, "R9", 1);
    step(0, 1, 0, 1, 0, 0, 0, "R9", 1);
    check32("R9", instrAddr, 32'hFFFF_FFFC);
    step(0, 0, 0, 0, 0, 0, 0, "R9", 1);
    check32("R9", instrAddr, 32'h0000_0000);

    // mixed strobes with occasional store writes
    for (int i = 0; i < 400; i++) begin
      logic [3:0] s;
      s = 4'($urandom);
      step(0, s[0], s[1] & s[2], s[3], (i % 17) == 0, int'($urandom % DEPTH),
           $urandom, "R2/R3/R5 mix", 1);
    end
    compareNow("R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule